// File: doc/BRIEF.md
# Coprocessor Host Register Bank

This block is the control and data register bank that a host processor sees when it talks to an attached coprocessor. The host reaches it through a 1 KB byte window. The bus decoder passes the low ten address bits as an offset, and the bank treats that offset as the low bits of the register address 0x7C00 | offset. Wide registers are built one byte at a time. They hold the DMA source, the DMA target, the DMA length, the program offset, the page number and the program counter. The bank also holds five narrow configuration fields, a 32-byte vector table and sixteen 24-bit general-purpose registers, packed three bytes per register.

Two writes do more than store data. Writing the top byte of the DMA target while the core is halted raises a one-cycle DMA request. Writing the program-counter byte while the core is halted raises a one-cycle start pulse. That pulse carries the entry address page×256 + PC, which the core loads before it leaves halt. A status byte built from the core's halt input reports whether the core is running or halted.

Top module: `cop_host_regs`

## Requirements
- R1: After reset every stored register reads 0x00, `dma_req` and `start` are low, and `dma_src`, `dma_dst` and `dma_len` are zero.
- R2: Offsets 0x340–0x342 hold the DMA source, 0x343–0x344 the DMA length and 0x345–0x347 the DMA target, least significant byte at the lowest offset. A write replaces only its own byte, and the values appear on `dma_src`, `dma_len` and `dma_dst` and read back unchanged.
- R3: A write to offset 0x347 while `core_halted` is 1 gives `dma_req` high for exactly the following cycle. The same write while the core runs gives no pulse.
- R4: Configuration fields keep only some bits of each write: offset 0x348 keeps bit 0, 0x34C keeps bits 1:0, 0x350 keeps mask 0x77, and 0x351 and 0x352 keep bit 0. Dropped bits read as 0.
- R5: The program offset sits at 0x349–0x34B, low byte first. The page number has its low byte at 0x34D and its high byte at 0x34E, which keeps only 7 bits.
- R6: A write to 0x34F stores the PC byte, which reads back. If `core_halted` is 1, `start` is high for the next cycle with `start_pc` = page×256 + written byte (23 bits). If the core runs, `start` stays low.
- R7: A read of any offset 0x353–0x35F returns 0x02 while `core_halted` is 1 and 0x40 while it is 0. Writes there have no effect.
- R8: Offsets 0x360–0x37F read and write vector byte [offset & 0x1F].
- R9: Offsets 0x380–0x3AF and their mirror 0x3C0–0x3EF reach the general-purpose registers. With k = offset & 0x3F, the register is k/3 and the byte lane is k mod 3, lane 0 being least significant.
- R10: Every other offset (below 0x340, 0x3B0–0x3BF, 0x3F0–0x3FF) reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_addr | input | 10 | Byte offset inside the 1 KB window |
| win_we | input | 1 | Write strobe |
| win_wdata | input | 8 | Write data |
| win_rdata | output | 8 | Read data for `win_addr`, combinational |
| core_halted | input | 1 | Core halt state |
| start | output | 1 | One-cycle start request |
| start_pc | output | 23 | Entry address presented with `start` |
| dma_req | output | 1 | One-cycle DMA request |
| dma_src | output | 24 | DMA source address |
| dma_dst | output | 24 | DMA target address |
| dma_len | output | 16 | DMA byte count |

## Verification
A table of write-then-read pairs drives the storage paths. Each pair either writes an all-ones byte to a masked field, which separates the kept bits from the dropped ones, or reads back through an alias (vector offset, GPR mirror), which separates correct folding from decoding the full offset. Directed sequences set and clear `core_halted` around writes to the trigger bytes. This shows that the pulses depend on the halt state and that `start_pc` combines page and PC in the right order. Writes to the status range and to holes in the map, each followed by reads, show those locations ignore data.

// File: rtl/cop_host_regs.sv
module cop_host_regs #(
  parameter int NGPR = 16,
  parameter int NVEC = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  win_addr,
  input  logic        win_we,
  input  logic [7:0]  win_wdata,
  output logic [7:0]  win_rdata,
  input  logic        core_halted,
  output logic        start,
  output logic [22:0] start_pc,
  output logic        dma_req,
  output logic [23:0] dma_src,
  output logic [23:0] dma_dst,
  output logic [15:0] dma_len
);
  localparam int VW = $clog2(NVEC);
  localparam int GW = $clog2(NGPR);

  logic [23:0] prog_off;
  logic [14:0] page;
  logic [7:0]  pc_byte;
  logic        cfg_a, cfg_d, cfg_e;
  logic [1:0]  cfg_b;
  logic [6:0]  cfg_c;
  logic [7:0]  vec [NVEC];
  logic [23:0] gpr [NGPR];

  logic          gpr_hit, vec_hit, stat_hit;
  logic [GW-1:0] g_idx;
  logic [1:0]    g_lane;

  assign gpr_hit  = (win_addr[9:7] == 3'b111) && (win_addr[5:4] != 2'b11);
  assign vec_hit  = (win_addr[9:5] == 5'b11011);
  assign stat_hit = (win_addr >= 10'h353) && (win_addr <= 10'h35F);

  always_comb begin
    g_idx  = '0;
    g_lane = '0;
    for (int i = 0; i < 48; i++)
      if (win_addr[5:0] == 6'(i)) begin
        g_idx  = GW'(i / 3);
        g_lane = 2'(i % 3);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_src <= '0; dma_dst <= '0; dma_len <= '0;
      prog_off <= '0; page <= '0; pc_byte <= '0;
      cfg_a <= 1'b0; cfg_b <= '0; cfg_c <= '0; cfg_d <= 1'b0; cfg_e <= 1'b0;
      start <= 1'b0; start_pc <= '0; dma_req <= 1'b0;
      for (int i = 0; i < NVEC; i++) vec[i] <= '0;
      for (int i = 0; i < NGPR; i++) gpr[i] <= '0;
    end else begin
      start   <= 1'b0;
      dma_req <= 1'b0;
      if (win_we) begin
        case (win_addr)
          10'h340: dma_src[7:0]    <= win_wdata;
          10'h341: dma_src[15:8]   <= win_wdata;
          10'h342: dma_src[23:16]  <= win_wdata;
          10'h343: dma_len[7:0]    <= win_wdata;
          10'h344: dma_len[15:8]   <= win_wdata;
          10'h345: dma_dst[7:0]    <= win_wdata;
          10'h346: dma_dst[15:8]   <= win_wdata;
          10'h347: begin
            dma_dst[23:16] <= win_wdata;
            dma_req        <= core_halted;
          end
          10'h348: cfg_a           <= win_wdata[0];
          10'h349: prog_off[7:0]   <= win_wdata;
          10'h34A: prog_off[15:8]  <= win_wdata;
          10'h34B: prog_off[23:16] <= win_wdata;
          10'h34C: cfg_b           <= win_wdata[1:0];
          10'h34D: page[7:0]       <= win_wdata;
          10'h34E: page[14:8]      <= win_wdata[6:0];
          10'h34F: begin
            pc_byte <= win_wdata;
            if (core_halted) begin
              start    <= 1'b1;
              start_pc <= {page, win_wdata};
            end
          end
          10'h350: cfg_c <= {win_wdata[6:4], 1'b0, win_wdata[2:0]};
          10'h351: cfg_d <= win_wdata[0];
          10'h352: cfg_e <= win_wdata[0];
          default: begin
            if (vec_hit) vec[win_addr[VW-1:0]] <= win_wdata;
            if (gpr_hit)
              case (g_lane)
                2'd0:    gpr[g_idx][7:0]   <= win_wdata;
                2'd1:    gpr[g_idx][15:8]  <= win_wdata;
                default: gpr[g_idx][23:16] <= win_wdata;
              endcase
          end
        endcase
      end
    end
  end

  always_comb begin
    win_rdata = 8'h00;
    case (win_addr)
      10'h340: win_rdata = dma_src[7:0];
      10'h341: win_rdata = dma_src[15:8];
      10'h342: win_rdata = dma_src[23:16];
      10'h343: win_rdata = dma_len[7:0];
      10'h344: win_rdata = dma_len[15:8];
      10'h345: win_rdata = dma_dst[7:0];
      10'h346: win_rdata = dma_dst[15:8];
      10'h347: win_rdata = dma_dst[23:16];
      10'h348: win_rdata = {7'b0, cfg_a};
      10'h349: win_rdata = prog_off[7:0];
      10'h34A: win_rdata = prog_off[15:8];
      10'h34B: win_rdata = prog_off[23:16];
      10'h34C: win_rdata = {6'b0, cfg_b};
      10'h34D: win_rdata = page[7:0];
      10'h34E: win_rdata = {1'b0, page[14:8]};
      10'h34F: win_rdata = pc_byte;
      10'h350: win_rdata = {1'b0, cfg_c};
      10'h351: win_rdata = {7'b0, cfg_d};
      10'h352: win_rdata = {7'b0, cfg_e};
      default: begin
        if (stat_hit)     win_rdata = {1'b0, !core_halted, 4'b0, core_halted, 1'b0};
        else if (vec_hit) win_rdata = vec[win_addr[VW-1:0]];
        else if (gpr_hit)
          case (g_lane)
            2'd0:    win_rdata = gpr[g_idx][7:0];
            2'd1:    win_rdata = gpr[g_idx][15:8];
            default: win_rdata = gpr[g_idx][23:16];
          endcase
      end
    endcase
  end

  assert_dma_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(win_we && win_addr == 10'h347 && core_halted));
  assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(win_we && win_addr == 10'h34F && core_halted));
  assert_start_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && win_addr == 10'h34F && core_halted) |=> (start_pc[7:0] == $past(win_wdata)));
  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (win_rdata == (core_halted ? 8'h02 : 8'h40)));
  assert_low_hole_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_addr < 10'h340) |-> (win_rdata == 8'h00));
  assert_cfg_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_addr == 10'h350) |-> (win_rdata[7] == 1'b0 && win_rdata[3] == 1'b0));
endmodule

// File: tb/cop_host_regs_test.sv
module cop_host_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  win_addr = '0;
  logic        win_we = 1'b0;
  logic [7:0]  win_wdata = '0;
  logic [7:0]  win_rdata;
  logic        core_halted = 1'b1;
  logic        start, dma_req;
  logic [22:0] start_pc;
  logic [23:0] dma_src, dma_dst;
  logic [15:0] dma_len;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cop_host_regs uut (.*);

  // {write offset, write data, read offset, expected}
  localparam int NT = 14;
  localparam logic [47:0] TBL [NT] = '{
    {16'h0340, 8'h11, 16'h0340, 8'h11},  // R2
    {16'h0343, 8'hA5, 16'h0343, 8'hA5},  // R2
    {16'h0348, 8'hFF, 16'h0348, 8'h01},  // R4
    {16'h034C, 8'hFF, 16'h034C, 8'h03},  // R4
    {16'h0350, 8'hFF, 16'h0350, 8'h77},  // R4
    {16'h0351, 8'hFF, 16'h0351, 8'h01},  // R4
    {16'h0352, 8'hFE, 16'h0352, 8'h00},  // R4
    {16'h034B, 8'hC3, 16'h034B, 8'hC3},  // R5
    {16'h034E, 8'hFF, 16'h034E, 8'h7F},  // R5
    {16'h0365, 8'hAB, 16'h0365, 8'hAB},  // R8
    {16'h0387, 8'h5A, 16'h03C7, 8'h5A},  // R9 reg2 lane1 via mirror
    {16'h03C9, 8'h3C, 16'h0389, 8'h3C},  // R9 reg3 lane0 via base
    {16'h03B0, 8'h99, 16'h03B0, 8'h00},  // R10
    {16'h0358, 8'hFF, 16'h0358, 8'h02}   // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    win_addr = a; win_wdata = d; win_we = 1'b1;
    @(negedge clk);
    win_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [7:0] exp);
    @(negedge clk);
    win_addr = a;
    #1 chk(req, {24'b0, win_rdata}, {24'b0, exp});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 10'h340, 8'h00);
    rd("R1", 10'h34F, 8'h00);
    rd("R1", 10'h3EF, 8'h00);
    rd("R1", 10'h37F, 8'h00);
    chk("R1", {7'b0, start, dma_req, 23'b0}, 32'h0);
    chk("R1", {8'b0, dma_src}, 32'h0);

    for (int i = 0; i < NT; i++) begin
      wr(TBL[i][41:32], TBL[i][31:24]);
      rd("table", TBL[i][17:8], TBL[i][7:0]);
    end

    // R2 byte lanes and outputs
    wr(10'h341, 8'h22); wr(10'h342, 8'h33);
    chk("R2", {8'b0, dma_src}, 32'h332211);
    wr(10'h340, 8'h44);
    chk("R2", {8'b0, dma_src}, 32'h332244);
    wr(10'h344, 8'h5B);
    chk("R2", {16'b0, dma_len}, 32'h5BA5);

    // R3 dma request while halted
    wr(10'h345, 8'h01); wr(10'h346, 8'h02);
    wr(10'h347, 8'h03);
    chk("R3", {31'b0, dma_req}, 32'h1);
    chk("R2", {8'b0, dma_dst}, 32'h030201);
    @(negedge clk);
    chk("R3", {31'b0, dma_req}, 32'h0);
    core_halted = 1'b0;
    wr(10'h347, 8'h07);
    chk("R3", {31'b0, dma_req}, 32'h0);
    rd("R2", 10'h347, 8'h07);

    // R7 running status
    rd("R7", 10'h353, 8'h40);
    rd("R7", 10'h35F, 8'h40);

    // R6 start while running: no pulse
    wr(10'h34D, 8'h12); wr(10'h34E, 8'h85);
    wr(10'h34F, 8'h9A);
    chk("R6", {31'b0, start}, 32'h0);
    rd("R6", 10'h34F, 8'h9A);
    rd("R5", 10'h34E, 8'h05);

    // R6 start while halted
    core_halted = 1'b1;
    wr(10'h34F, 8'h34);
    chk("R6", {31'b0, start}, 32'h1);
    chk("R6", {9'b0, start_pc}, 32'h051234);
    @(negedge clk);
    chk("R6", {31'b0, start}, 32'h0);

    // R9 last register, all lanes, mirror
    wr(10'h3AD, 8'hA1); wr(10'h3EE, 8'hB2); wr(10'h3AF, 8'hC3);
    rd("R9", 10'h3ED, 8'hA1);
    rd("R9", 10'h3AE, 8'hB2);
    rd("R9", 10'h3EF, 8'hC3);
    rd("R9", 10'h3AC, 8'h00);

    // R8 vector boundaries
    wr(10'h360, 8'h5C); wr(10'h37F, 8'hE7);
    rd("R8", 10'h360, 8'h5C);
    rd("R8", 10'h37F, 8'hE7);

    // R10 holes ignore writes
    wr(10'h3F5, 8'h66); rd("R10", 10'h3F5, 8'h00);
    wr(10'h33F, 8'h66); rd("R10", 10'h33F, 8'h00);
    rd("R10", 10'h3AD, 8'hA1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule